// File: doc/BRIEF.md
# Parallel Multi-Polynomial PRBS Pattern Source

This block is the pattern source for transmit lane testing. Each accepted transfer carries a 64-bit word of pseudo-random bits. The words come from a linear feedback shift register that is advanced 64 steps in a single cycle. A 4-bit mode input chooses one of five maximal-length polynomials at run time. Plain configuration inputs control the source: an enable, a re-seed control, a 64-bit error-injection mask given as two 32-bit halves, and a bus-select bit.

When bus-select picks the pattern, the generated word, XORed with the mask, is placed on the output stream. When bus-select picks normal traffic, the ordinary transmit stream passes through unchanged. Both the transmit input and the output use valid/ready handshakes:
- The output holds `out_valid` and `out_data` unchanged until `out_ready` is sampled high.
- A new word is loaded on any edge where the output slot is empty or being emptied.
- `tx_ready` is high only while normal traffic is selected and the slot can take a word.
- The generator advances only when a pattern word is loaded, so back-pressure never skips pattern bits.

Top module: `prbs_pattern_gen`

## Requirements
- R1: Mode 0, 1, 2, 3 and 4 select x^7+x^6+1, x^9+x^5+1, x^11+x^9+1, x^23+x^18+1 and x^31+x^28+1. For a polynomial of order N with tap T, each step computes f = s[N-1] ^ s[T-1] on the low N state bits and then shifts: s = {s[N-2:0], f}. The k-th bit produced in a word (k = 0 first) appears on out_data[k].
- R2: While cfg_enable is low, no pattern word is loaded and the generator state does not move. After enable returns high, the next word continues the sequence.
- R3: Reset and a high cfg_init each load the all-ones seed. While cfg_init is high, no pattern word is loaded. The first word after init is the first word of the seed sequence.
- R4: A loaded pattern word equals the generated bits XOR {cfg_mask_hi, cfg_mask_lo}, with cfg_mask_hi covering bits 63:32. A zero mask leaves the pattern unchanged.
- R5: With cfg_sel_pattern low, tx_data passes to out_data unchanged, with no mask applied. With cfg_sel_pattern high, tx_ready stays low.
- R6: Successive pattern words continue one unbroken bit sequence, 64 new bits per accepted word.
- R7: The state register is 31 bits wide and is shared by all modes. A mode of order N writes its N-bit result back zero-extended. If the low N bits are all zero when a word is generated, the generator uses all ones in their place.
- R8: Mode values 5 to 15 behave exactly like mode 4.
- R9: While out_valid is high and out_ready is low, out_valid and out_data hold, and the generator does not advance.
- R10: After reset, out_valid is low, and tx_ready is high whenever cfg_sel_pattern is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 4 | Polynomial select |
| cfg_enable | input | 1 | Allows pattern words to be produced |
| cfg_init | input | 1 | Re-seeds the generator with all ones |
| cfg_mask_hi | input | 32 | Error-injection mask, bits 63:32 |
| cfg_mask_lo | input | 32 | Error-injection mask, bits 31:0 |
| cfg_sel_pattern | input | 1 | 1 = pattern drives the output, 0 = normal traffic |
| tx_data | input | 64 | Normal transmit word |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Block accepts tx_data |
| out_data | output | 64 | Output word |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Downstream accepts out_data |

## Verification
Each of the five polynomials and two aliased mode codes is run from the all-ones seed for several consecutive words. These runs distinguish wrong taps, wrong bit order and broken word-to-word continuity. Separate runs apply a mask on only the upper half and then only the lower half, which shows the two halves are not swapped. A long PRBS31 run is stopped at the exact point where its low seven state bits are zero and then switched to PRBS7, which exercises the lock-up guard. Stalls, enable gaps and mid-run re-seeds show whether bits are skipped or repeated. Pass-through words with a nonzero mask confirm that normal traffic is never altered.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int DATA_W    = 64;
  localparam int STATE_W   = 31;
  localparam int NUM_POLY  = 5;
  localparam int IDX_W     = $clog2(NUM_POLY);
  localparam int MODE_W    = 4;

  // order of each polynomial, indexed by decoded mode
  function automatic int poly_order(input int idx);
    case (idx)
      0:       return 7;
      1:       return 9;
      2:       return 11;
      3:       return 23;
      default: return 31;
    endcase
  endfunction

  // second feedback tap of each polynomial
  function automatic int poly_tap(input int idx);
    case (idx)
      0:       return 6;
      1:       return 5;
      2:       return 9;
      3:       return 18;
      default: return 28;
    endcase
  endfunction

  // codes above the last polynomial fold onto the longest one
  function automatic logic [IDX_W-1:0] mode_to_idx(input logic [MODE_W-1:0] m);
    if (m < MODE_W'(NUM_POLY)) return IDX_W'(m);
    return IDX_W'(NUM_POLY - 1);
  endfunction
endpackage

// File: rtl/prbs_unroll.sv
// One polynomial advanced W steps in a single combinational pass.
module prbs_unroll #(
  parameter int ORDER = 7,
  parameter int TAP   = 6,
  parameter int W     = 64
) (
  input  logic [ORDER-1:0] cur_state,
  output logic [W-1:0]     word,
  output logic [ORDER-1:0] next_state
);
  always_comb begin
    logic [ORDER-1:0] s;
    logic             fb;
    // lock-up guard: an all-zero state restarts from all ones
    s = (cur_state == '0) ? '1 : cur_state;
    word = '0;
    for (int i = 0; i < W; i++) begin
      fb      = s[ORDER-1] ^ s[TAP-1];
      word[i] = fb;
      s       = {s[ORDER-2:0], fb};
    end
    next_state = s;
  end
endmodule

// File: rtl/prbs_engine.sv
// Shared state register plus one unrolled step network per polynomial.
module prbs_engine
  import prbs_gen_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              init,
  input  logic              advance,
  output logic [W-1:0]      pat_word
);
  localparam logic [STATE_W-1:0] SEED = '1;

  logic [STATE_W-1:0] state_q;
  logic [IDX_W-1:0]   idx;
  logic [W-1:0]       words [NUM_POLY];
  logic [STATE_W-1:0] nexts [NUM_POLY];
  logic [STATE_W-1:0] next_sel;

  assign idx = mode_to_idx(mode);

  for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
    localparam int ORD = poly_order(g);
    localparam int TP  = poly_tap(g);
    logic [ORD-1:0] nx;
    prbs_unroll #(.ORDER(ORD), .TAP(TP), .W(W)) u_step (
      .cur_state (state_q[ORD-1:0]),
      .word      (words[g]),
      .next_state(nx)
    );
    assign nexts[g] = STATE_W'(nx);
  end

  always_comb begin
    pat_word = words[NUM_POLY-1];
    next_sel = nexts[NUM_POLY-1];
    for (int i = 0; i < NUM_POLY; i++) begin
      if (idx == IDX_W'(i)) begin
        pat_word = words[i];
        next_sel = nexts[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= SEED;
    else if (init)    state_q <= SEED;
    else if (advance) state_q <= next_sel;
  end

  a_r3_init_seeds: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (state_q == SEED));
  a_r9_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !advance) |=> $stable(state_q));
  a_r7_state_live: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (state_q != '0));
endmodule

// File: rtl/prbs_out_stage.sv
// Source select, error mask and the registered valid/ready output slot.
module prbs_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_pattern,
  input  logic         enable,
  input  logic         init,
  input  logic [W-1:0] pat_word,
  input  logic [W-1:0] err_mask,
  input  logic [W-1:0] tx_data,
  input  logic         tx_valid,
  output logic         tx_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         advance
);
  logic         valid_q;
  logic [W-1:0] data_q;
  logic         slot_free;
  logic         take_tx;

  assign slot_free = !valid_q || out_ready;
  assign advance   = slot_free && sel_pattern && enable && !init;
  assign tx_ready  = slot_free && !sel_pattern;
  assign take_tx   = tx_ready && tx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (slot_free) begin
      valid_q <= advance || take_tx;
      if (advance)      data_q <= pat_word ^ err_mask;
      else if (take_tx) data_q <= tx_data;
    end
  end

  assign out_data  = data_q;
  assign out_valid = valid_q;

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r5_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pattern |-> !tx_ready);
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pattern && !enable && slot_free) |=> !out_valid);
  a_r3_no_word_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pattern && init && slot_free) |=> !out_valid);
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_gen_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_enable,
  input  logic              cfg_init,
  input  logic [DW/2-1:0]   cfg_mask_hi,
  input  logic [DW/2-1:0]   cfg_mask_lo,
  input  logic              cfg_sel_pattern,
  input  logic [DW-1:0]     tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_valid,
  input  logic              out_ready
);
  logic [DW-1:0] pat_word;
  logic          advance;

  prbs_engine #(.W(DW)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (cfg_mode),
    .init    (cfg_init),
    .advance (advance),
    .pat_word(pat_word)
  );

  prbs_out_stage #(.W(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_pattern(cfg_sel_pattern),
    .enable     (cfg_enable),
    .init       (cfg_init),
    .pat_word   (pat_word),
    .err_mask   ({cfg_mask_hi, cfg_mask_lo}),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .advance    (advance)
  );
endmodule

// File: tb/prbs_pattern_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_pattern_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_mode = 4'd0;
  logic        cfg_enable = 1'b0;
  logic        cfg_init = 1'b0;
  logic [31:0] cfg_mask_hi = '0;
  logic [31:0] cfg_mask_lo = '0;
  logic        cfg_sel_pattern = 1'b0;
  logic [63:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [63:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [30:0] mst;

  always #2.5 clk = ~clk;

  prbs_pattern_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_enable(cfg_enable),
    .cfg_init(cfg_init), .cfg_mask_hi(cfg_mask_hi), .cfg_mask_lo(cfg_mask_lo),
    .cfg_sel_pattern(cfg_sel_pattern), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // serial reference: one bit per step on the shared 31-bit model state
  task automatic model_word(input logic [3:0] m, output logic [63:0] w);
    int ord, tp;
    logic [30:0] msk, s;
    logic b;
    case (m)
      4'd0: begin ord = 7;  tp = 6;  end
      4'd1: begin ord = 9;  tp = 5;  end
      4'd2: begin ord = 11; tp = 9;  end
      4'd3: begin ord = 23; tp = 18; end
      default: begin ord = 31; tp = 28; end
    endcase
    msk = 31'h7FFF_FFFF >> (31 - ord);
    s = mst & msk;
    if (s == '0) s = msk;
    for (int i = 0; i < 64; i++) begin
      b = s[ord-1] ^ s[tp-1];
      w[i] = b;
      s = ((s << 1) | {30'd0, b}) & msk;
    end
    mst = s;
  endtask

  // drain the slot, seed, then load the first word; returns with word in slot
  task automatic restart(input logic [3:0] m);
    @(negedge clk);
    cfg_sel_pattern = 1'b1; cfg_enable = 1'b0; out_ready = 1'b1;
    cfg_mode = m; cfg_init = 1'b1;
    @(negedge clk);
    cfg_init = 1'b0; out_ready = 1'b0; cfg_enable = 1'b1;
    mst = '1;
    @(negedge clk);
  endtask

  task automatic fetch();
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    check(tx_ready == 1'b1, "R10 tx_ready after reset", 64'(tx_ready), 64'd1);
  endtask

  task automatic t_poly(input logic [3:0] m, input string req);
    logic [63:0] e;
    restart(m);
    model_word(m, e);
    check(out_valid && out_data == e, req, out_data, e);
    for (int k = 0; k < 3; k++) begin
      fetch();
      model_word(m, e);
      check(out_valid && out_data == e, {req, " R6 continuation"}, out_data, e);
    end
  endtask

  task automatic t_mask();
    logic [63:0] e;
    cfg_mask_hi = 32'h8000_0001; cfg_mask_lo = 32'h0;
    restart(4'd1);
    model_word(4'd1, e);
    check(out_data == (e ^ 64'h8000_0001_0000_0000), "R4 upper mask",
          out_data, e ^ 64'h8000_0001_0000_0000);
    cfg_mask_hi = 32'h0; cfg_mask_lo = 32'h0000_00F0;
    fetch();
    model_word(4'd1, e);
    check(out_data == (e ^ 64'hF0), "R4 lower mask", out_data, e ^ 64'hF0);
    cfg_mask_lo = 32'h0;
    fetch();
    model_word(4'd1, e);
    check(out_data == e, "R4 zero mask", out_data, e);
  endtask

  task automatic t_enable();
    logic [63:0] e;
    restart(4'd2);
    model_word(4'd2, e);
    @(negedge clk); cfg_enable = 1'b0; out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R2 no word while disabled", 64'(out_valid), 64'd0);
    end
    out_ready = 1'b0; cfg_enable = 1'b1;
    @(negedge clk);
    model_word(4'd2, e);
    check(out_valid && out_data == e, "R2 resumes without skip", out_data, e);
  endtask

  task automatic t_stall();
    logic [63:0] e;
    restart(4'd3);
    model_word(4'd3, e);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid && out_data == e, "R9 held under stall", out_data, e);
    end
    fetch();
    model_word(4'd3, e);
    check(out_data == e, "R9 no advance while stalled", out_data, e);
  endtask

  task automatic t_init();
    logic [63:0] e;
    restart(4'd2);
    model_word(4'd2, e);
    fetch(); model_word(4'd2, e);
    @(negedge clk); cfg_init = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R3 no word during init", 64'(out_valid), 64'd0);
    cfg_init = 1'b0; out_ready = 1'b0; mst = '1;
    @(negedge clk);
    model_word(4'd2, e);
    check(out_valid && out_data == e, "R3 restart from seed", out_data, e);
  endtask

  task automatic t_zero_guard();
    logic [63:0] e;
    bit found = 0;
    restart(4'd4);
    model_word(4'd4, e);
    for (int k = 0; k < 4000 && !found; k++) begin
      if (mst[6:0] == 7'd0) found = 1;
      else begin fetch(); model_word(4'd4, e); end
    end
    check(found, "R7 zero low bits reached", 64'(found), 64'd1);
    check(out_data == e, "R7 PRBS31 run before switch", out_data, e);
    @(negedge clk); cfg_mode = 4'd0;
    fetch(); model_word(4'd0, e);
    check(out_data == e, "R7 guard on zero state", out_data, e);
    fetch(); model_word(4'd0, e);
    check(out_data == e, "R7 after guard", out_data, e);
  endtask

  task automatic t_passthru();
    @(negedge clk);
    cfg_enable = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    cfg_sel_pattern = 1'b0; out_ready = 1'b0;
    cfg_mask_hi = 32'hFFFF_FFFF; cfg_mask_lo = 32'h1234_5678;
    tx_data = 64'hDEAD_BEEF_0BAD_F00D; tx_valid = 1'b1;
    @(negedge clk);
    check(out_valid && out_data == 64'hDEAD_BEEF_0BAD_F00D, "R5 passthrough unmasked",
          out_data, 64'hDEAD_BEEF_0BAD_F00D);
    check(tx_ready == 1'b0, "R9 tx back-pressured", 64'(tx_ready), 64'd0);
    tx_data = 64'h0123_4567_89AB_CDEF; out_ready = 1'b1;
    @(negedge clk);
    check(out_data == 64'h0123_4567_89AB_CDEF, "R5 second tx word", out_data,
          64'h0123_4567_89AB_CDEF);
    tx_valid = 1'b0; cfg_sel_pattern = 1'b1;
    @(negedge clk);
    check(tx_ready == 1'b0, "R5 tx_ready low in pattern mode", 64'(tx_ready), 64'd0);
    cfg_mask_hi = '0; cfg_mask_lo = '0; out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_poly(4'd0, "R1 PRBS7");
    t_poly(4'd1, "R1 PRBS9");
    t_poly(4'd2, "R1 PRBS11");
    t_poly(4'd3, "R1 PRBS23");
    t_poly(4'd4, "R1 PRBS31");
    t_poly(4'd9, "R8 mode 9 alias");
    t_poly(4'd15, "R8 mode 15 alias");
    t_mask();
    t_enable();
    t_stall();
    t_init();
    t_zero_guard();
    t_passthru();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule